// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block turns the interrupt causes of one UART channel into a single active-low interrupt request and a six-bit identification code for software to read. It watches eight causes. Three are levels taken straight from the datapath: the aggregate receive-error flag, the receive time-out and receive-data-ready. The rest are events: transmit space, modem-input change, general-purpose-input change, flow-control detection (an Xoff character or a special character), and a handshake pin (CTS or RTS) going inactive. Each cause has its own enable bit. Each has a pending bit that is cleared by its own rule.

When software reads the identification register, the host-side decoder pulses `id_rd` once at the start of the read. At that edge the code of the highest-priority enabled pending cause is captured into `id_code`, and the causes that clear on a read are cleared. The code then stays fixed until the next read strobe. The interrupt output follows the pending state on every cycle.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `irq_n` is 1 and `id_code` is 000001 (bit 0 set means nothing pending).
- R2: Each cause is reported with a fixed code: receive error 000110, receive time-out 001100, receive data 000100, transmit space 000010, modem change 000000, GPIO change 110000, flow control 010000, handshake 100000.
- R3: With several enabled causes pending, the read reports the most urgent one. The order from most to least urgent is: receive error, receive time-out, receive data, transmit space, modem, GPIO, flow control, handshake.
- R4: Receive time-out and receive data share one urgency level. When both are pending, the time-out code 001100 is reported.
- R5: A cause whose enable bit (bit index = position in the R3 order, 0 = receive error) is 0 never drives `irq_n` low and never appears in `id_code`. An event that arrives while its cause is disabled is not recorded.
- R6: `irq_n` is 0 exactly when at least one enabled cause is pending. It reflects an input event one clock after that event is sampled.
- R7: The receive-error, time-out and data causes follow their input levels with one cycle of delay. They are not cleared by reads.
- R8: The transmit-space cause is cleared by a read that reports it, or by `thr_wr`. A new event in the same cycle wins over the clear.
- R9: A flow-control interrupt caused by `xoff_det` stays pending across reads and is cleared only by `xon_det`.
- R10: A flow-control interrupt caused by `spec_det` is cleared by a read that reports the flow-control code.
- R11: The handshake cause is set only when `cts_n` or `rts_n` goes from 0 to 1. A 1-to-0 change sets nothing.
- R12: `id_code` changes only at a cycle with `id_rd` high. It captures the code that is live in that cycle.
- R13: The modem, GPIO and handshake causes are cleared by a read that reports them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | 8 | Per-cause enable, bit index = urgency order |
| rx_err_any | input | 1 | Level: an error exists anywhere in the receive queue |
| rx_timeout | input | 1 | Level: stale receive data time-out |
| rx_ready | input | 1 | Level: receive data ready / trigger reached |
| tx_space_ev | input | 1 | Pulse: transmit empty / trigger reached |
| modem_chg_ev | input | 1 | Pulse: modem input changed |
| gpio_chg_ev | input | 1 | Pulse: general-purpose input changed |
| xoff_det | input | 1 | Pulse: Xoff character detected |
| spec_det | input | 1 | Pulse: special character detected |
| xon_det | input | 1 | Pulse: Xon character detected |
| cts_n | input | 1 | CTS pin level, active low |
| rts_n | input | 1 | RTS pin level, active low |
| thr_wr | input | 1 | Pulse: write to transmit holding register |
| id_rd | input | 1 | Pulse: start of identification-register read |
| irq_n | output | 1 | Interrupt request, active low |
| id_code | output | 6 | Captured identification code |

## Verification
The block is built with its package defaults: eight causes and a six-bit code. These are fixed by the code table, so every cause, every pairing of causes and every clear rule can be reached. Random enables, events, pin toggles and read strobes run against a bench model of the pending bits. This reaches same-cycle set-and-clear collisions, reads that land on a masked winner, and Xoff and special causes pending together. Directed cases pin down each code, the shared urgency level, and the separate Xoff and special-character clears.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int SRC_N  = 8;
    localparam int CODE_W = 6;
    localparam int IDX_W  = $clog2(SRC_N);

    typedef enum logic [IDX_W-1:0] {
        SRC_LINE  = 3'd0,
        SRC_RXTO  = 3'd1,
        SRC_RXDAT = 3'd2,
        SRC_TXE   = 3'd3,
        SRC_MODEM = 3'd4,
        SRC_GPIO  = 3'd5,
        SRC_FLOW  = 3'd6,
        SRC_HSK   = 3'd7
    } src_e;

    typedef struct packed {
        logic valid;
        src_e idx;
    } pick_t;

    localparam logic [CODE_W-1:0] CODE_NONE = 6'b000001;

    // Fixed identification code per cause.
    function automatic logic [CODE_W-1:0] code_of(src_e s);
        case (s)
            SRC_LINE:  code_of = 6'b000110;
            SRC_RXTO:  code_of = 6'b001100;
            SRC_RXDAT: code_of = 6'b000100;
            SRC_TXE:   code_of = 6'b000010;
            SRC_MODEM: code_of = 6'b000000;
            SRC_GPIO:  code_of = 6'b110000;
            SRC_FLOW:  code_of = 6'b010000;
            default:   code_of = 6'b100000;
        endcase
    endfunction

    // Causes held as event-set / read-clear pending bits.
    function automatic bit is_event_src(int i);
        return (i == int'(SRC_TXE)) || (i == int'(SRC_MODEM)) ||
               (i == int'(SRC_GPIO)) || (i == int'(SRC_HSK));
    endfunction

endpackage

// File: rtl/uirq_capture.sv
module uirq_capture
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] en,
    input  logic             rx_err_any,
    input  logic             rx_timeout,
    input  logic             rx_ready,
    input  logic             tx_ev,
    input  logic             modem_ev,
    input  logic             gpio_ev,
    input  logic             xoff_det,
    input  logic             spec_det,
    input  logic             xon_det,
    input  logic             cts_n,
    input  logic             rts_n,
    input  logic             thr_wr,
    input  logic [SRC_N-1:0] rd_hit,
    output logic [SRC_N-1:0] pend
);

    logic [2:0]       lvl_q;
    logic             xoff_q, spec_q;
    logic             cts_q, rts_q;
    logic             hsk_rise;
    logic [SRC_N-1:0] ev, clr, pend_ev;

    assign hsk_rise = (cts_n & ~cts_q) | (rts_n & ~rts_q);

    always_comb begin
        ev             = '0;
        ev[SRC_TXE]    = tx_ev;
        ev[SRC_MODEM]  = modem_ev;
        ev[SRC_GPIO]   = gpio_ev;
        ev[SRC_HSK]    = hsk_rise;
        clr            = rd_hit;
        clr[SRC_TXE]   = rd_hit[SRC_TXE] | thr_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            xoff_q <= 1'b0;
            spec_q <= 1'b0;
            cts_q  <= cts_n;
            rts_q  <= rts_n;
        end else begin
            lvl_q  <= {rx_ready, rx_timeout, rx_err_any};
            xoff_q <= (xoff_det & en[SRC_FLOW]) | (xoff_q & ~xon_det);
            spec_q <= (spec_det & en[SRC_FLOW]) | (spec_q & ~rd_hit[SRC_FLOW]);
            cts_q  <= cts_n;
            rts_q  <= rts_n;
        end
    end

    generate
        for (genvar i = 0; i < SRC_N; i++) begin : g_src
            if (is_event_src(i)) begin : g_ev
                logic q;
                always_ff @(posedge clk) begin
                    if (rst) q <= 1'b0;
                    else     q <= (ev[i] & en[i]) | (q & ~clr[i]);
                end
                assign pend_ev[i] = q;
            end else begin : g_none
                assign pend_ev[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        pend            = pend_ev;
        pend[SRC_LINE]  = lvl_q[0];
        pend[SRC_RXTO]  = lvl_q[1];
        pend[SRC_RXDAT] = lvl_q[2];
        pend[SRC_FLOW]  = xoff_q | spec_q;
    end

    // R9: an Xoff cause survives reads until an Xon arrives
    assert_xoff_held_R9: assert property (@(posedge clk) disable iff (rst)
        (xoff_q && !xon_det) |=> pend[SRC_FLOW]);

    // R11: handshake pending only appears after an inactive-going pin edge
    assert_hsk_rise_only_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[SRC_HSK]) |-> $past(hsk_rise));

    // R8: holding-register write clears transmit cause unless a new event lands
    assert_tx_thr_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (pend[SRC_TXE] && thr_wr && !tx_ev) |=> !pend[SRC_TXE]);

endmodule

// File: rtl/uirq_pick.sv
module uirq_pick
    import uirq_pkg::*;
(
    input  logic [SRC_N-1:0] req,
    output logic [SRC_N-1:0] grant,
    output pick_t            win
);

    logic [SRC_N:0] above;
    assign above[0] = 1'b0;

    generate
        for (genvar i = 0; i < SRC_N; i++) begin : g_chain
            assign grant[i]    = req[i] & ~above[i];
            assign above[i+1]  = above[i] | req[i];
        end
    endgenerate

    always_comb begin
        win.valid = above[SRC_N];
        win.idx   = SRC_LINE;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (grant[i]) win.idx = src_e'(IDX_W'(i));
        end
    end

endmodule

// File: rtl/uirq_idreg.sv
module uirq_idreg
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  pick_t             win,
    output logic [CODE_W-1:0] id_code
);

    logic [CODE_W-1:0] live;
    assign live = win.valid ? code_of(win.idx) : CODE_NONE;

    always_ff @(posedge clk) begin
        if (rst)     id_code <= CODE_NONE;
        else if (rd) id_code <= live;
    end

    // R12: code is frozen between read strobes
    assert_code_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(id_code));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  src_en,
    input  logic              rx_err_any,
    input  logic              rx_timeout,
    input  logic              rx_ready,
    input  logic              tx_space_ev,
    input  logic              modem_chg_ev,
    input  logic              gpio_chg_ev,
    input  logic              xoff_det,
    input  logic              spec_det,
    input  logic              xon_det,
    input  logic              cts_n,
    input  logic              rts_n,
    input  logic              thr_wr,
    input  logic              id_rd,
    output logic              irq_n,
    output logic [CODE_W-1:0] id_code
);

    logic [SRC_N-1:0] pend, masked, grant, rd_hit;
    pick_t            win;

    assign masked = pend & src_en;
    assign irq_n  = ~(|masked);
    assign rd_hit = id_rd ? grant : '0;

    uirq_capture i_capture (
        .clk        (clk),
        .rst        (rst),
        .en         (src_en),
        .rx_err_any (rx_err_any),
        .rx_timeout (rx_timeout),
        .rx_ready   (rx_ready),
        .tx_ev      (tx_space_ev),
        .modem_ev   (modem_chg_ev),
        .gpio_ev    (gpio_chg_ev),
        .xoff_det   (xoff_det),
        .spec_det   (spec_det),
        .xon_det    (xon_det),
        .cts_n      (cts_n),
        .rts_n      (rts_n),
        .thr_wr     (thr_wr),
        .rd_hit     (rd_hit),
        .pend       (pend)
    );

    uirq_pick i_pick (
        .req   (masked),
        .grant (grant),
        .win   (win)
    );

    uirq_idreg i_idreg (
        .clk     (clk),
        .rst     (rst),
        .rd      (id_rd),
        .win     (win),
        .id_code (id_code)
    );

    // R3: at most one cause wins
    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R5: a disabled cause is never the winner
    assert_masked_R5: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> src_en[win.idx]);

    // R6: request line agrees with the picker
    assert_irq_agrees_R6: assert property (@(posedge clk) disable iff (rst)
        irq_n == !win.valid);

    // R4: time-out outranks data at the shared level
    assert_rxto_first_R4: assert property (@(posedge clk) disable iff (rst)
        masked[SRC_RXTO] |-> (win.idx != SRC_RXDAT));

endmodule

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] en;
    logic       err, rto, rdy, txe, mdm, gpi, xoff, spec, xon, cts_n, rts_n, thr, rd;
    logic       irq_n;
    logic [5:0] id_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state
    logic [7:0] m_p;
    logic       m_xq, m_sq, m_pc, m_pr;
    logic [5:0] m_id;

    always #2 clk = ~clk;

    uart_irq_ident i_uart_irq_ident (
        .clk(clk), .rst(rst), .src_en(en),
        .rx_err_any(err), .rx_timeout(rto), .rx_ready(rdy),
        .tx_space_ev(txe), .modem_chg_ev(mdm), .gpio_chg_ev(gpi),
        .xoff_det(xoff), .spec_det(spec), .xon_det(xon),
        .cts_n(cts_n), .rts_n(rts_n), .thr_wr(thr), .id_rd(rd),
        .irq_n(irq_n), .id_code(id_code)
    );

    function automatic logic [5:0] code_exp(int s);
        case (s)
            0: return 6'b000110;
            1: return 6'b001100;
            2: return 6'b000100;
            3: return 6'b000010;
            4: return 6'b000000;
            5: return 6'b110000;
            6: return 6'b010000;
            7: return 6'b100000;
            default: return 6'b000001;
        endcase
    endfunction

    function automatic logic [7:0] mpend();
        logic [7:0] p = m_p;
        p[6] = m_xq | m_sq;
        return p;
    endfunction

    function automatic int mpick(logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic clear_pulses();
        txe = 0; mdm = 0; gpi = 0; xoff = 0; spec = 0; xon = 0; thr = 0; rd = 0;
    endtask

    // One clock: predict, clock, compare irq_n (and id_code on a read).
    task automatic step(input string tag);
        logic [7:0] np;
        logic       nxq, nsq, rise;
        logic [5:0] nid;
        int         rep;
        bit         was_rd;
        rep  = mpick(mpend() & en);
        rise = (cts_n & ~m_pc) | (rts_n & ~m_pr);
        np    = '0;
        np[0] = err; np[1] = rto; np[2] = rdy;
        np[3] = (txe & en[3]) | (m_p[3] & ~thr & ~(rd && rep == 3));
        np[4] = (mdm & en[4]) | (m_p[4] & ~(rd && rep == 4));
        np[5] = (gpi & en[5]) | (m_p[5] & ~(rd && rep == 5));
        np[7] = (rise & en[7]) | (m_p[7] & ~(rd && rep == 7));
        nxq   = (xoff & en[6]) | (m_xq & ~xon);
        nsq   = (spec & en[6]) | (m_sq & ~(rd && rep == 6));
        nid   = rd ? code_exp(rep) : m_id;
        was_rd = rd;
        @(posedge clk); #1;
        m_p = np; m_xq = nxq; m_sq = nsq; m_pc = cts_n; m_pr = rts_n; m_id = nid;
        chk({tag, " irq_n R6"}, {7'd0, irq_n}, {7'd0, ~(|(mpend() & en))});
        if (was_rd) chk({tag, " id_code R12"}, {2'd0, id_code}, {2'd0, m_id});
        clear_pulses();
    endtask

    task automatic read_code(input string tag, input logic [5:0] exp);
        rd = 1; step(tag);
        chk(tag, {2'd0, id_code}, {2'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; en = 8'hFF; err = 0; rto = 0; rdy = 0; cts_n = 0; rts_n = 0;
        clear_pulses();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        m_p = '0; m_xq = 0; m_sq = 0; m_pc = cts_n; m_pr = rts_n; m_id = 6'b000001;

        // R1: reset state
        chk("R1 irq_n", {7'd0, irq_n}, 8'd1);
        chk("R1 id_code", {2'd0, id_code}, 8'b000001);
        read_code("R1 idle read", 6'b000001);

        // R2: each cause alone
        for (int s = 0; s < 8; s++) begin
            case (s)
                0: err = 1; 1: rto = 1; 2: rdy = 1; 3: txe = 1;
                4: mdm = 1; 5: gpi = 1; 6: spec = 1; default: cts_n = 1;
            endcase
            step("R2 set");
            read_code($sformatf("R2 code src%0d", s), code_exp(s));
            err = 0; rto = 0; rdy = 0; cts_n = 0;
            step("R2 clean");
            chk($sformatf("R2 idle after src%0d", s), {7'd0, irq_n}, 8'd1);
        end

        // R4: time-out and data together
        rto = 1; rdy = 1; step("R4 set");
        read_code("R4 shared level", 6'b001100);
        rto = 0; step("R4 drop");
        read_code("R4 data next", 6'b000100);
        rdy = 0; step("R4 clean");

        // R3 / R7: error outranks transmit; level not cleared by read
        err = 1; txe = 1; step("R3 set");
        read_code("R3 error first", 6'b000110);
        read_code("R7 level survives read", 6'b000110);
        err = 0; step("R7 drop");
        read_code("R3 tx next", 6'b000010);
        chk("R8 tx cleared by read", {7'd0, irq_n}, 8'd1);

        // R8: holding-register write clears
        txe = 1; step("R8 set");
        chk("R8 pending", {7'd0, irq_n}, 8'd0);
        thr = 1; step("R8 write");
        chk("R8 write clears", {7'd0, irq_n}, 8'd1);

        // R9: Xoff only cleared by Xon
        xoff = 1; step("R9 set");
        read_code("R9 code", 6'b010000);
        chk("R9 still pending after read", {7'd0, irq_n}, 8'd0);
        xon = 1; step("R9 xon");
        chk("R9 cleared by xon", {7'd0, irq_n}, 8'd1);

        // R10: special character cleared by read
        spec = 1; step("R10 set");
        read_code("R10 code", 6'b010000);
        chk("R10 cleared by read", {7'd0, irq_n}, 8'd1);

        // R11: active-going edge sets nothing; inactive-going sets
        rts_n = 1; step("R11 rise");
        rts_n = 0; step("R11 fall");
        read_code("R11 rise reported", 6'b100000);
        chk("R11 fall sets nothing", {7'd0, irq_n}, 8'd1);

        // R13: modem and gpio read-cleared in order
        mdm = 1; gpi = 1; step("R13 set");
        read_code("R13 modem", 6'b000000);
        read_code("R13 gpio", 6'b110000);
        chk("R13 both cleared", {7'd0, irq_n}, 8'd1);

        // R5: disabled event not recorded; disabled level hidden
        en = 8'hEF; mdm = 1; step("R5 masked event");
        chk("R5 masked no irq", {7'd0, irq_n}, 8'd1);
        en = 8'hFF; step("R5 reenable");
        chk("R5 event not recorded", {7'd0, irq_n}, 8'd1);
        en = 8'hFE; err = 1; step("R5 masked level");
        read_code("R5 masked level hidden", 6'b000001);
        err = 0; en = 8'hFF; step("R5 clean");

        // R12: code holds without a read
        gpi = 1; step("R12 set");
        read_code("R12 capture", 6'b110000);
        mdm = 1; step("R12 new cause");
        chk("R12 held", {2'd0, id_code}, 8'b110000);
        read_code("R12 recapture", 6'b000000);

        // random phase
        for (int c = 0; c < 4000; c++) begin
            en   = ($urandom % 4 == 0) ? 8'($urandom) : 8'hFF;
            if ($urandom % 6 == 0) err = ~err;
            if ($urandom % 6 == 0) rto = ~rto;
            if ($urandom % 6 == 0) rdy = ~rdy;
            if ($urandom % 6 == 0) cts_n = ~cts_n;
            if ($urandom % 6 == 0) rts_n = ~rts_n;
            txe  = ($urandom % 8 == 0);
            mdm  = ($urandom % 8 == 0);
            gpi  = ($urandom % 8 == 0);
            xoff = ($urandom % 10 == 0);
            spec = ($urandom % 10 == 0);
            xon  = ($urandom % 8 == 0);
            thr  = ($urandom % 8 == 0);
            rd   = ($urandom % 3 == 0);
            step("rand R3");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule